// File: doc/BRIEF.md
# Downstream Port Status and Control Registers

This block holds one 16-bit status/control word for each downstream port of a host controller's root hub. There are two ports by default. Software reaches the words through a word-addressed register window. Device attach and detach events arrive on per-port strobes, and each attach event carries a low-speed flag. The block keeps each word up to date from three sources: software writes, attach and detach events, and a global reset issued by the controller.

Software can enable a port and can start a bus reset on it. A rising write of the reset bit sends a one-cycle `busReset` pulse to the device on that port. Change bits are cleared by writing a one to them. A one-cycle `resumeReq` pulse tells the controller's command block that a connect or enable event has happened. `portEnabled` mirrors each port's enable bit so that the traffic engine can gate packets.

Top module: `hub_port_regs`

Bit layout of each word: bit 0 connected, bit 1 connect changed, bit 2 enabled, bit 3 enable changed, bit 7 reads as one, bit 8 low-speed device, bit 9 port reset. The word address is the byte offset divided by two. Port n sits at word address 8+n, so port 0 is at byte 0x10 and port 1 is at byte 0x12.

## Requirements
- R1: After `rst_n` is released, every port word reads 0x0080, `portEnabled` is 0 and neither pulse output is high.
- R2: For a word address, bit 3 selects the port window and bits 2:0 give the port index. An address outside the window, or an index at or above NUM_PORTS, reads 0xFF7F and ignores writes.
- R3: An accepted write keeps bits 0, 1 and 3 to 8 (mask 0x01FB) at their stored value. Bit 2 and bits 9 to 15 take the written value.
- R4: After the merge of R3, bits 1 and 3 are cleared wherever the written data has a one.
- R5: `busReset[n]` is high for exactly the one cycle after an accepted write to port n whose data has bit 9 set while the stored bit 9 was clear. Otherwise it is low.
- R6: A write to a port with no device attached leaves its word unchanged and produces no `busReset`.
- R7: An attach strobe on port n sets bits 0 and 1 and copies `lowSpeed[n]` into bit 8. `resumeReq` is then high for the next cycle. Attach and detach are never asserted together on one port.
- R8: A detach strobe on a connected port clears bit 0 and sets bit 1. If the port was enabled, it also clears bit 2, sets bit 3 and raises `resumeReq` for the next cycle. A detach on a port that is not enabled raises no `resumeReq`.
- R9: `gReset` returns every word to 0x0080, which clears `portEnabled`. For each port that still has a device attached, it then re-applies the attach update of R7, including the low-speed bit recorded at attach time, and raises `resumeReq`.
- R10: `portEnabled[n]` equals bit 2 of port n's word at all times.
- R11: When an attach or detach event hits a port in the same cycle as a write or `gReset`, the event is applied after the write or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gReset | input | 1 | Global reset strobe from the controller |
| wrEn | input | 1 | Word write strobe |
| wordAddr | input | 4 | Word address (byte offset divided by 2) |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data for `wordAddr`, combinational |
| attach | input | NUM_PORTS | Per-port device attach strobe |
| detach | input | NUM_PORTS | Per-port device detach strobe |
| lowSpeed | input | NUM_PORTS | Speed of the device attaching, sampled with `attach` |
| busReset | output | NUM_PORTS | One-cycle reset pulse to the device on each port |
| resumeReq | output | 1 | One-cycle resume request to the controller |
| portEnabled | output | NUM_PORTS | Enable bit of each port word |

## Verification
The assertions assume that attach and detach never strobe the same port in the same cycle. They also assume that every input is at a known value from time zero. The bench drives every input from tasks on the falling clock edge, starting with all strobes low. It raises attach and detach through separate tasks, one event per call. The only exception is the deliberate overlap of a write with a detach, which exercises the ordering of R11. No overlap of attach with detach is ever driven.

// File: rtl/hubPortPkg.sv
package hubPortPkg;
  localparam int IDX_W = 3;
  localparam int WORD_W = 16;

  localparam int BIT_CONN     = 0;
  localparam int BIT_CONN_CHG = 1;
  localparam int BIT_EN       = 2;
  localparam int BIT_EN_CHG   = 3;
  localparam int BIT_LOW_SPD  = 8;
  localparam int BIT_PRST     = 9;

  localparam logic [WORD_W-1:0] KEEP_MASK  = 16'h01FB;
  localparam logic [WORD_W-1:0] W1C_MASK   = 16'h000A;
  localparam logic [WORD_W-1:0] RESET_WORD = 16'h0080;
  localparam logic [WORD_W-1:0] EMPTY_WORD = 16'hFF7F;

  typedef struct packed {
    logic             globalRst;
    logic             wrHit;
    logic             idxValid;
    logic [IDX_W-1:0] idx;
  } portStrobes_t;
endpackage

// File: rtl/hubPortCtrl.sv
module hubPortCtrl
  import hubPortPkg::*;
#(
  parameter int NUM_PORTS = 2
) (
  input  logic         gReset,
  input  logic         wrEn,
  input  logic [3:0]   wordAddr,
  output portStrobes_t strb
);
  logic inWindow;
  logic inRange;

  assign inWindow = wordAddr[3];
  assign inRange  = 32'(wordAddr[2:0]) < NUM_PORTS;

  always_comb begin
    strb.globalRst = gReset;
    strb.idx       = wordAddr[2:0];
    strb.idxValid  = inWindow && inRange;
    strb.wrHit     = wrEn && inWindow && inRange;
  end
endmodule

// File: rtl/hubPortDatapath.sv
module hubPortDatapath
  import hubPortPkg::*;
#(
  parameter int NUM_PORTS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  portStrobes_t         strb,
  input  logic [WORD_W-1:0]    wrData,
  input  logic [NUM_PORTS-1:0] attach,
  input  logic [NUM_PORTS-1:0] detach,
  input  logic [NUM_PORTS-1:0] lowSpeed,
  output logic [WORD_W-1:0]    rdData,
  output logic [NUM_PORTS-1:0] busReset,
  output logic [NUM_PORTS-1:0] portEnabled,
  output logic                 resumeReq
);
  logic [WORD_W-1:0]    rdCand [NUM_PORTS];
  logic [NUM_PORTS-1:0] resVec;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : gPort
    logic [WORD_W-1:0] regQ, regN;
    logic presQ, presN, lowQ, lowN, pulseQ, pulseN, resN, wrSel;

    assign wrSel = strb.wrHit && (strb.idx == IDX_W'(p));

    always_comb begin
      regN   = regQ;
      presN  = presQ;
      lowN   = lowQ;
      pulseN = 1'b0;
      resN   = 1'b0;
      if (strb.globalRst) begin
        regN = RESET_WORD;
        if (presQ) begin
          regN[BIT_CONN]     = 1'b1;
          regN[BIT_CONN_CHG] = 1'b1;
          regN[BIT_LOW_SPD]  = lowQ;
          resN               = 1'b1;
        end
      end else if (wrSel && presQ) begin
        pulseN = wrData[BIT_PRST] & ~regQ[BIT_PRST];
        regN   = (regQ & KEEP_MASK) | (wrData & ~KEEP_MASK);
        regN   = regN & ~(wrData & W1C_MASK);
      end
      if (attach[p]) begin
        regN[BIT_CONN]     = 1'b1;
        regN[BIT_CONN_CHG] = 1'b1;
        regN[BIT_LOW_SPD]  = lowSpeed[p];
        presN              = 1'b1;
        lowN               = lowSpeed[p];
        resN               = 1'b1;
      end else if (detach[p]) begin
        if (regN[BIT_CONN]) begin
          regN[BIT_CONN]     = 1'b0;
          regN[BIT_CONN_CHG] = 1'b1;
        end
        if (regN[BIT_EN]) begin
          regN[BIT_EN]     = 1'b0;
          regN[BIT_EN_CHG] = 1'b1;
          resN             = 1'b1;
        end
        presN = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regQ   <= RESET_WORD;
        presQ  <= 1'b0;
        lowQ   <= 1'b0;
        pulseQ <= 1'b0;
      end else begin
        regQ   <= regN;
        presQ  <= presN;
        lowQ   <= lowN;
        pulseQ <= pulseN;
      end
    end

    assign rdCand[p]      = regQ;
    assign resVec[p]      = resN;
    assign busReset[p]    = pulseQ;
    assign portEnabled[p] = regQ[BIT_EN];
  end

  always_comb begin
    rdData = EMPTY_WORD;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (strb.idxValid && strb.idx == IDX_W'(p)) rdData = rdCand[p];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) resumeReq <= 1'b0;
    else        resumeReq <= |resVec;
  end
endmodule

// File: rtl/hub_port_regs.sv
module hub_port_regs
  import hubPortPkg::*;
#(
  parameter int NUM_PORTS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 gReset,
  input  logic                 wrEn,
  input  logic [3:0]           wordAddr,
  input  logic [15:0]          wrData,
  output logic [15:0]          rdData,
  input  logic [NUM_PORTS-1:0] attach,
  input  logic [NUM_PORTS-1:0] detach,
  input  logic [NUM_PORTS-1:0] lowSpeed,
  output logic [NUM_PORTS-1:0] busReset,
  output logic                 resumeReq,
  output logic [NUM_PORTS-1:0] portEnabled
);
  portStrobes_t strb;

  hubPortCtrl #(.NUM_PORTS(NUM_PORTS)) u_ctrl (
    .gReset   (gReset),
    .wrEn     (wrEn),
    .wordAddr (wordAddr),
    .strb     (strb)
  );

  hubPortDatapath #(.NUM_PORTS(NUM_PORTS)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strb        (strb),
    .wrData      (wrData),
    .attach      (attach),
    .detach      (detach),
    .lowSpeed    (lowSpeed),
    .rdData      (rdData),
    .busReset    (busReset),
    .portEnabled (portEnabled),
    .resumeReq   (resumeReq)
  );
endmodule

// File: rtl/hub_port_regs_chk.sv
module hub_port_regs_chk #(
  parameter int NUM_PORTS = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 gReset,
  input logic                 wrEn,
  input logic [3:0]           wordAddr,
  input logic [15:0]          wrData,
  input logic [15:0]          rdData,
  input logic [NUM_PORTS-1:0] attach,
  input logic [NUM_PORTS-1:0] detach,
  input logic [NUM_PORTS-1:0] busReset,
  input logic                 resumeReq,
  input logic [NUM_PORTS-1:0] portEnabled
);
  // R7: input assumption, attach and detach never overlap on a port
  a_r7_events_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (attach & detach) == '0);

  a_r7_resume_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    resumeReq |-> $past((|attach) || (|detach) || gReset));

  a_r9_greset_disables: assert property (@(posedge clk) disable iff (!rst_n)
    (gReset && attach == '0) |=> portEnabled == '0);

  a_r2_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!wordAddr[3] || 32'(wordAddr[2:0]) >= NUM_PORTS) |-> rdData == 16'hFF7F);

  for (genvar i = 0; i < NUM_PORTS; i++) begin : gChk
    a_r5_pulse_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
      busReset[i] |-> $past(wrEn && wordAddr == 4'(8 + i) && wrData[9]));

    a_r5_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      busReset[i] |=> !busReset[i]);

    a_r8_detach_disables: assert property (@(posedge clk) disable iff (!rst_n)
      detach[i] |=> !portEnabled[i]);
  end
endmodule

bind hub_port_regs hub_port_regs_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .gReset      (gReset),
  .wrEn        (wrEn),
  .wordAddr    (wordAddr),
  .wrData      (wrData),
  .rdData      (rdData),
  .attach      (attach),
  .detach      (detach),
  .busReset    (busReset),
  .resumeReq   (resumeReq),
  .portEnabled (portEnabled)
);

// File: tb/hub_port_regs_tb.sv
module hub_port_regs_tb;
  localparam int NP = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gReset = 1'b0;
  logic wrEn = 1'b0;
  logic [3:0] wordAddr = 4'd0;
  logic [15:0] wrData = 16'd0;
  logic [15:0] rdData;
  logic [NP-1:0] attach = '0, detach = '0, lowSpeed = '0;
  logic [NP-1:0] busReset, portEnabled;
  logic resumeReq;

  int total = 0, passed = 0;
  bit done = 1'b0;
  logic [15:0] model [NP];

  always #4 clk = ~clk;

  hub_port_regs #(.NUM_PORTS(NP)) u_dut (
    .clk(clk), .rst_n(rst_n), .gReset(gReset), .wrEn(wrEn),
    .wordAddr(wordAddr), .wrData(wrData), .rdData(rdData),
    .attach(attach), .detach(detach), .lowSpeed(lowSpeed),
    .busReset(busReset), .resumeReq(resumeReq), .portEnabled(portEnabled)
  );

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (ok) passed++;
    else $display("FAIL %s actual=%h expected=%h", tag, act, exp);
  endtask

  function automatic logic [15:0] fWrite(input logic [15:0] old, input logic [15:0] wd);
    logic [15:0] v;
    v = (old & 16'h01FB) | (wd & 16'hFE04);
    return v & ~(wd & 16'h000A);
  endfunction

  function automatic logic [15:0] fAttach(input logic [15:0] old, input logic low);
    logic [15:0] v;
    v = old | 16'h0003;
    v[8] = low;
    return v;
  endfunction

  function automatic logic [15:0] fDetach(input logic [15:0] old);
    logic [15:0] v;
    v = old;
    if (v[0]) begin v[0] = 1'b0; v[1] = 1'b1; end
    if (v[2]) begin v[2] = 1'b0; v[3] = 1'b1; end
    return v;
  endfunction

  task automatic readWord(input logic [3:0] a, output logic [15:0] d);
    wordAddr = a;
    #1;
    d = rdData;
  endtask

  task automatic doWrite(input logic [3:0] a, input logic [15:0] d);
    wordAddr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic pulseAttach(input int p, input logic low);
    attach[p] = 1'b1; lowSpeed[p] = low;
    @(negedge clk);
    attach[p] = 1'b0;
  endtask

  task automatic pulseDetach(input int p);
    detach[p] = 1'b1;
    @(negedge clk);
    detach[p] = 1'b0;
  endtask

  task automatic checkPorts(input string tag);
    logic [15:0] d;
    for (int p = 0; p < NP; p++) begin
      readWord(4'(8 + p), d);
      chk(d == model[p], tag, d, model[p]);
      chk(portEnabled[p] == model[p][2], "R10 portEnabled", 16'(portEnabled[p]), 16'(model[p][2]));
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", passed, total);
      $finish;
    end
  end

  initial begin
    logic [15:0] d, old;
    logic [15:0] pats [4];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int p = 0; p < NP; p++) model[p] = 16'h0080;
    checkPorts("R1 reset word");
    chk(resumeReq == 1'b0 && busReset == '0, "R1 pulses idle", {busReset, 13'd0, resumeReq}, 16'd0);

    // R6 write with no device present
    doWrite(4'd8, 16'h0204);
    chk(busReset == '0, "R6 no busReset", 16'(busReset), 16'd0);
    checkPorts("R6 write ignored");

    // R7 attach: low-speed on port 0, full-speed on port 1
    pulseAttach(0, 1'b1);
    model[0] = fAttach(model[0], 1'b1);
    chk(resumeReq == 1'b1, "R7 resume on attach", 16'(resumeReq), 16'd1);
    checkPorts("R7 attach low");
    pulseAttach(1, 1'b0);
    model[1] = fAttach(model[1], 1'b0);
    chk(resumeReq == 1'b1, "R7 resume on attach", 16'(resumeReq), 16'd1);
    checkPorts("R7 attach full");
    @(negedge clk);
    chk(resumeReq == 1'b0, "R7 resume one cycle", 16'(resumeReq), 16'd0);

    // R2 sweep of every word address for reads, then writes outside range
    for (int a = 0; a < 16; a++) begin
      logic [15:0] e;
      readWord(4'(a), d);
      e = (a == 8) ? model[0] : (a == 9) ? model[1] : 16'hFF7F;
      chk(d == e, "R2 read decode", d, e);
    end
    for (int a = 0; a < 16; a++) begin
      if (a != 8 && a != 9) begin
        doWrite(4'(a), 16'hFFFF);
        chk(busReset == '0, "R2 stray write no pulse", 16'(busReset), 16'd0);
      end
    end
    checkPorts("R2 stray writes ignored");

    // R4 change bits cleared by writing one
    doWrite(4'd8, 16'h000A);
    model[0] = fWrite(model[0], 16'h000A);
    checkPorts("R4 w1c");

    // R3/R4/R5 sweep of single-bit and mixed patterns on both ports
    pats[0] = 16'hFFFF; pats[1] = 16'h0000; pats[2] = 16'h5A5A; pats[3] = 16'hA5A5;
    for (int p = 0; p < NP; p++) begin
      for (int k = 0; k < 20; k++) begin
        logic [15:0] wd;
        logic expPulse;
        wd = (k < 16) ? (16'h1 << k) : pats[k-16];
        old = model[p];
        expPulse = wd[9] & ~old[9];
        doWrite(4'(8 + p), wd);
        model[p] = fWrite(old, wd);
        chk(busReset[p] == expPulse, "R5 busReset on write", 16'(busReset[p]), 16'(expPulse));
        checkPorts("R3 merge sweep");
      end
    end

    // R5 explicit edge behaviour
    doWrite(4'd8, 16'h0000); model[0] = fWrite(model[0], 16'h0000);
    doWrite(4'd8, 16'h0200); model[0] = fWrite(model[0], 16'h0200);
    chk(busReset[0] == 1'b1, "R5 pulse on rising reset bit", 16'(busReset[0]), 16'd1);
    @(negedge clk);
    chk(busReset[0] == 1'b0, "R5 pulse lasts one cycle", 16'(busReset[0]), 16'd0);
    doWrite(4'd8, 16'h0200); model[0] = fWrite(model[0], 16'h0200);
    chk(busReset[0] == 1'b0, "R5 no pulse when already set", 16'(busReset[0]), 16'd0);

    // R8 detach of an enabled port and of a port that is not enabled
    doWrite(4'd8, 16'h0004); model[0] = fWrite(model[0], 16'h0004);
    doWrite(4'd9, 16'h0000); model[1] = fWrite(model[1], 16'h0000);
    checkPorts("R8 setup");
    pulseDetach(0);
    model[0] = fDetach(model[0]);
    chk(resumeReq == 1'b1, "R8 resume on enabled detach", 16'(resumeReq), 16'd1);
    checkPorts("R8 detach enabled");
    @(negedge clk);
    pulseDetach(1);
    model[1] = fDetach(model[1]);
    chk(resumeReq == 1'b0, "R8 no resume when not enabled", 16'(resumeReq), 16'd0);
    checkPorts("R8 detach idle");

    // R9 global reset with port 0 present (full speed) and port 1 absent
    pulseAttach(0, 1'b0);
    model[0] = fAttach(model[0], 1'b0);
    doWrite(4'd8, 16'h0004); model[0] = fWrite(model[0], 16'h0004);
    @(negedge clk);
    gReset = 1'b1;
    @(negedge clk);
    gReset = 1'b0;
    model[0] = 16'h0083; model[1] = 16'h0080;
    chk(resumeReq == 1'b1, "R9 resume after reattach", 16'(resumeReq), 16'd1);
    checkPorts("R9 global reset");

    // R11 write and detach in the same cycle: detach applied last
    wordAddr = 4'd8; wrData = 16'h0004; wrEn = 1'b1; detach[0] = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; detach[0] = 1'b0;
    model[0] = fDetach(fWrite(model[0], 16'h0004));
    chk(resumeReq == 1'b1, "R11 resume after ordered detach", 16'(resumeReq), 16'd1);
    checkPorts("R11 event after write");

    // R6 after detach the port ignores writes again
    doWrite(4'd8, 16'h020E);
    chk(busReset[0] == 1'b0, "R6 no pulse when absent", 16'(busReset[0]), 16'd0);
    checkPorts("R6 absent after detach");

    done = 1'b1;
    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end
endmodule